// File: doc/BRIEF.md
# Prioritized Two-Output Interrupt Controller

This block gathers up to 32 active-low interrupt lines and presents them to a processor on two request outputs: a normal one (IRQ) and a fast one (FIQ). Software programs it over a simple 32-bit register bus with an address, a read strobe, a write strobe and write data. Read data is combinational and is valid while the read strobe is high. Each line has its own configuration word with three fields. The first picks the output the line feeds. The second picks how the line is detected: falling edge or low level. The third is a 5-bit priority.

Pending bits are gathered from the inputs and from a software-set register. A mask register gates them. For each output, an arbiter picks a winner among the pending, unmasked lines routed to that output. Reading an output's source-code register returns the winner's line number and acknowledges it. The acknowledge clears that line's pending bit. It also parks the output's request state machine until software re-arms it through the control register.

Each output has a two-state machine. In `ARB_LIVE`, the request follows the arbiter. In `ARB_HELD`, the request is forced low. The transition `ack` (a source-code read) moves `ARB_LIVE` to `ARB_HELD`. The transition `rearm` (a control write with the output's bit set) moves `ARB_HELD` back to `ARB_LIVE`. Reset enters `ARB_LIVE`.

Top module: `prio_intc`

## Requirements
- R1: After reset, both request outputs are low, the pending register reads 0, the mask register reads 0xFFFFFFFF, every line configuration word reads 0, and both state machines are in ARB_LIVE.
- R2: The register at an offset is selected by address bits 7:0 only; the other address bits are ignored. The offsets are: pending 0x00, mask 0x04, IRQ code 0x10, FIQ code 0x14, control 0x18, line n configuration 0x1C+4n, software-set 0x9C. Unlisted offsets read 0.
- R3: A line configuration word keeps bit 0 as route (1 = FIQ, 0 = IRQ), bit 1 as sensitivity (0 = falling edge, 1 = low level) and bits 6:2 as priority. A read returns those fields in the same bits, with zeros above them.
- R4: A falling-edge line sets its pending bit at the clock edge that follows a high-to-low change of its input. Holding the input low does not set the bit again.
- R5: A level line sets its pending bit on every clock edge at which its input is low.
- R6: A write to the pending register ANDs the write data into the pending bits. A bit whose line is level-sensitive and whose input is currently low stays set.
- R7: A mask bit of 1 disables its line. A mask write replaces the whole mask, and both outputs reflect the new mask from the next cycle. Masking does not change the pending bits.
- R8: For each output, the winner is the pending, unmasked line routed to that output with the numerically lowest priority. Equal priorities go to the lowest line number.
- R9: Reading a code register returns the current winner's line number in bits 4:0 and clears that line's pending bit at the clock edge of the read. When no line is eligible, the read returns 0 and clears nothing.
- R10: After a code read, that output stays low until the control register is written with its bit set (bit 0 for IRQ, bit 1 for FIQ). The other output is unaffected.
- R11: Writes to the two code registers change no state.
- R12: The control and software-set registers read 0.
- R13: Writing the software-set register sets the pending bit of each line whose data bit is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_n | input | NUM_LINES | Interrupt inputs, active low, synchronous to clk |
| bus_addr | input | 32 | Register byte address; bits 7:0 are decoded |
| bus_rd | input | 1 | Read strobe; a code-register read acknowledges at the clock edge |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from the current address |
| irq_req_o | output | 1 | Normal interrupt request |
| fiq_req_o | output | 1 | Fast interrupt request |

## Verification
The assertions assume that the interrupt inputs are already synchronous to the clock. They also assume that a read and a write are never strobed in the same cycle, so an acknowledge and a re-arm of one output cannot coincide. The stimulus changes inputs and strobes only on the falling clock edge, and each bus access is a single cycle. Each strobe is released before the next access starts. Lines that a scenario does not use are held high, so only the intended lines can become pending.

// File: rtl/intc_pkg.sv
package intc_pkg;

    parameter int unsigned PRIO_W = 5;

    // Register offsets (address bits 7:0)
    localparam logic [7:0] OFF_PEND     = 8'h00;
    localparam logic [7:0] OFF_MASK     = 8'h04;
    localparam logic [7:0] OFF_IRQ_CODE = 8'h10;
    localparam logic [7:0] OFF_FIQ_CODE = 8'h14;
    localparam logic [7:0] OFF_CTRL     = 8'h18;
    localparam logic [7:0] OFF_CFG_BASE = 8'h1C;
    localparam logic [7:0] OFF_SWSET    = 8'h9C;

    typedef enum logic {
        ROUTE_IRQ = 1'b0,
        ROUTE_FIQ = 1'b1
    } route_e;

    typedef enum logic {
        ARB_LIVE = 1'b0,
        ARB_HELD = 1'b1
    } arb_state_e;

    // Packed so that the field layout matches the register bits 6:0
    typedef struct packed {
        logic [PRIO_W-1:0] prio;
        logic              level;
        route_e            route;
    } line_cfg_t;

endpackage

// File: rtl/intc_line_bank.sv
module intc_line_bank
    import intc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic [NUM_LINES-1:0]            line_n,
    input  logic                            cfg_we,
    input  logic [IDX_W-1:0]                cfg_idx,
    input  line_cfg_t                       cfg_wdata,
    input  logic                            pend_we,
    input  logic [NUM_LINES-1:0]            pend_wdata,
    input  logic                            sw_we,
    input  logic [NUM_LINES-1:0]            sw_wdata,
    input  logic [NUM_LINES-1:0]            ack_clr,
    output logic [NUM_LINES-1:0]            pend_o,
    output line_cfg_t [NUM_LINES-1:0]       cfg_o
);

    logic [NUM_LINES-1:0] prev_q;
    logic [NUM_LINES-1:0] level_vec;
    logic [NUM_LINES-1:0] level_low;
    logic [NUM_LINES-1:0] edge_fall;
    logic [NUM_LINES-1:0] keep_mask;
    logic [NUM_LINES-1:0] set_vec;
    logic [NUM_LINES-1:0] pend_d;

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_line
            assign level_vec[g] = cfg_o[g].level;

            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    cfg_o[g] <= '0;
                end else if (cfg_we && (cfg_idx == IDX_W'(g))) begin
                    cfg_o[g] <= cfg_wdata;
                end
            end

            // R4
            edge_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (prev_q[g] && !line_n[g] && !cfg_o[g].level) |=> pend_o[g]);

            // R5
            level_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (cfg_o[g].level && !line_n[g]) |=> pend_o[g]);

            // R13
            swset_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
                (sw_we && sw_wdata[g]) |=> pend_o[g]);
        end
    endgenerate

    assign level_low = level_vec & ~line_n;
    assign edge_fall = prev_q & ~line_n & ~level_vec;
    assign keep_mask = pend_we ? (pend_wdata | level_low) : '1;
    assign set_vec   = edge_fall | level_low | (sw_we ? sw_wdata : '0);
    assign pend_d    = (pend_o & keep_mask & ~ack_clr) | set_vec;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= '1;
            pend_o <= '0;
        end else begin
            prev_q <= line_n;
            pend_o <= pend_d;
        end
    end

endmodule

// File: rtl/intc_arbiter.sv
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter route_e      SEL_ROUTE = ROUTE_IRQ,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES)
) (
    input  logic [NUM_LINES-1:0]      pend_i,
    input  logic [NUM_LINES-1:0]      mask_i,
    input  line_cfg_t [NUM_LINES-1:0] cfg_i,
    output logic                      valid_o,
    output logic [IDX_W-1:0]          idx_o
);

    logic [NUM_LINES-1:0] cand;
    logic [PRIO_W-1:0]    best_prio;

    generate
        for (genvar g = 0; g < NUM_LINES; g++) begin : g_cand
            assign cand[g] = pend_i[g] && !mask_i[g] && (cfg_i[g].route == SEL_ROUTE);
        end
    endgenerate

    // Scan from the top down; "<=" lets a lower index take a tie.
    always_comb begin
        valid_o   = 1'b0;
        idx_o     = '0;
        best_prio = '1;
        for (int i = NUM_LINES - 1; i >= 0; i--) begin
            if (cand[i] && (!valid_o || (cfg_i[i].prio <= best_prio))) begin
                valid_o   = 1'b1;
                idx_o     = IDX_W'(i);
                best_prio = cfg_i[i].prio;
            end
        end
    end

endmodule

// File: rtl/intc_out_ctl.sv
module intc_out_ctl
    import intc_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic win_valid_i,
    input  logic ack_i,
    input  logic rearm_i,
    output logic req_o
);

    arb_state_e state_q;
    arb_state_e state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ARB_LIVE;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ARB_LIVE: if (ack_i)   state_d = ARB_HELD;
            ARB_HELD: if (rearm_i) state_d = ARB_LIVE;
            default:               state_d = ARB_LIVE;
        endcase
    end

    always_comb begin
        req_o = (state_q == ARB_LIVE) && win_valid_i;
    end

    // R10
    ack_parks_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_i && !rearm_i) |=> !req_o);

endmodule

// File: rtl/prio_intc.sv
module prio_intc
    import intc_pkg::*;
#(
    parameter int unsigned NUM_LINES = 32,
    parameter int unsigned DATA_W    = 32,
    localparam int unsigned IDX_W    = $clog2(NUM_LINES),
    localparam int unsigned CFG_W    = $bits(line_cfg_t),
    localparam int          CFG_END  = int'(OFF_CFG_BASE) + 4 * NUM_LINES
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [NUM_LINES-1:0] line_n,
    input  logic [31:0]          bus_addr,
    input  logic                 bus_rd,
    input  logic                 bus_wr,
    input  logic [DATA_W-1:0]    bus_wdata,
    output logic [DATA_W-1:0]    bus_rdata,
    output logic                 irq_req_o,
    output logic                 fiq_req_o
);

    logic [7:0]                off;
    logic                      unused_addr_hi;
    logic                      cfg_hit;
    logic [7:0]                cfg_rel;
    logic [IDX_W-1:0]          cfg_idx;
    logic [NUM_LINES-1:0]      pend;
    logic [NUM_LINES-1:0]      mask_q;
    line_cfg_t [NUM_LINES-1:0] cfg;
    logic                      irq_valid, fiq_valid;
    logic [IDX_W-1:0]          irq_idx, fiq_idx;
    logic                      irq_ack, fiq_ack;
    logic                      irq_rearm, fiq_rearm;
    logic [NUM_LINES-1:0]      ack_clr;

    assign off            = bus_addr[7:0];
    assign unused_addr_hi = ^bus_addr[31:8];

    assign cfg_hit = (int'(off) >= int'(OFF_CFG_BASE)) && (int'(off) < CFG_END) &&
                     (off[1:0] == 2'b00);
    assign cfg_rel = off - OFF_CFG_BASE;
    assign cfg_idx = cfg_rel[IDX_W+1:2];

    assign irq_ack   = bus_rd && (off == OFF_IRQ_CODE);
    assign fiq_ack   = bus_rd && (off == OFF_FIQ_CODE);
    assign irq_rearm = bus_wr && (off == OFF_CTRL) && bus_wdata[0];
    assign fiq_rearm = bus_wr && (off == OFF_CTRL) && bus_wdata[1];

    always_comb begin
        ack_clr = '0;
        if (irq_ack && irq_valid) ack_clr[irq_idx] = 1'b1;
        if (fiq_ack && fiq_valid) ack_clr[fiq_idx] = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            mask_q <= '1;
        end else if (bus_wr && (off == OFF_MASK)) begin
            mask_q <= bus_wdata[NUM_LINES-1:0];
        end
    end

    intc_line_bank #(.NUM_LINES(NUM_LINES)) u_lines (
        .clk        (clk),
        .rst_n      (rst_n),
        .line_n     (line_n),
        .cfg_we     (bus_wr && cfg_hit),
        .cfg_idx    (cfg_idx),
        .cfg_wdata  (line_cfg_t'(bus_wdata[CFG_W-1:0])),
        .pend_we    (bus_wr && (off == OFF_PEND)),
        .pend_wdata (bus_wdata[NUM_LINES-1:0]),
        .sw_we      (bus_wr && (off == OFF_SWSET)),
        .sw_wdata   (bus_wdata[NUM_LINES-1:0]),
        .ack_clr    (ack_clr),
        .pend_o     (pend),
        .cfg_o      (cfg)
    );

    intc_arbiter #(.NUM_LINES(NUM_LINES), .SEL_ROUTE(ROUTE_IRQ)) u_arb_irq (
        .pend_i  (pend),
        .mask_i  (mask_q),
        .cfg_i   (cfg),
        .valid_o (irq_valid),
        .idx_o   (irq_idx)
    );

    intc_arbiter #(.NUM_LINES(NUM_LINES), .SEL_ROUTE(ROUTE_FIQ)) u_arb_fiq (
        .pend_i  (pend),
        .mask_i  (mask_q),
        .cfg_i   (cfg),
        .valid_o (fiq_valid),
        .idx_o   (fiq_idx)
    );

    intc_out_ctl u_ctl_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_valid_i (irq_valid),
        .ack_i       (irq_ack),
        .rearm_i     (irq_rearm),
        .req_o       (irq_req_o)
    );

    intc_out_ctl u_ctl_fiq (
        .clk         (clk),
        .rst_n       (rst_n),
        .win_valid_i (fiq_valid),
        .ack_i       (fiq_ack),
        .rearm_i     (fiq_rearm),
        .req_o       (fiq_req_o)
    );

    always_comb begin
        bus_rdata = '0;
        if (cfg_hit) begin
            bus_rdata[CFG_W-1:0] = cfg[cfg_idx];
        end else begin
            case (off)
                OFF_PEND:     bus_rdata[NUM_LINES-1:0] = pend;
                OFF_MASK:     bus_rdata[NUM_LINES-1:0] = mask_q;
                OFF_IRQ_CODE: bus_rdata[IDX_W-1:0]     = irq_valid ? irq_idx : '0;
                OFF_FIQ_CODE: bus_rdata[IDX_W-1:0]     = fiq_valid ? fiq_idx : '0;
                default:      bus_rdata                = '0;
            endcase
        end
    end

    // R8
    irq_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_req_o |-> (pend[irq_idx] && !mask_q[irq_idx] && cfg[irq_idx].route == ROUTE_IRQ));

    // R8
    fiq_winner_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fiq_req_o |-> (pend[fiq_idx] && !mask_q[fiq_idx] && cfg[fiq_idx].route == ROUTE_FIQ));

    // R7
    mask_all_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_wr && off == OFF_MASK && &bus_wdata[NUM_LINES-1:0]) |=> (!irq_req_o && !fiq_req_o));

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ack && irq_valid && !cfg[irq_idx].level && !bus_wr) |=> !pend[$past(irq_idx)]);

endmodule

// File: tb/prio_intc_tb.sv
module prio_intc_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] line_n = '1;
    logic [31:0] bus_addr = '0;
    logic        bus_rd = 1'b0;
    logic        bus_wr = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_req_o, fiq_req_o;

    int errors = 0;
    int checks = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    prio_intc u_dut (
        .clk       (clk),
        .rst_n     (rst_n),
        .line_n    (line_n),
        .bus_addr  (bus_addr),
        .bus_rd    (bus_rd),
        .bus_wr    (bus_wr),
        .bus_wdata (bus_wdata),
        .bus_rdata (bus_rdata),
        .irq_req_o (irq_req_o),
        .fiq_req_o (fiq_req_o)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic bus_write(input logic [31:0] a, input logic [31:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic bus_read(input logic [31:0] a, output logic [31:0] d);
        bus_addr = a;
        bus_rd   = 1'b1;
        #1;
        d = bus_rdata;
        tick();
        bus_rd   = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d;
        check("R1 irq after reset", {31'b0, irq_req_o}, 32'h0);
        check("R1 fiq after reset", {31'b0, fiq_req_o}, 32'h0);
        bus_read(32'h00, d); check("R1 pending after reset", d, 32'h0);
        bus_read(32'h04, d); check("R1 mask after reset", d, 32'hFFFF_FFFF);
        bus_read(32'h98, d); check("R1 line31 cfg after reset", d, 32'h0);
    endtask

    task automatic t_map();
        logic [31:0] d;
        bus_write(32'hABCD_0104, 32'h1234_5678);
        bus_read(32'h04, d);  check("R2 mask written via alias", d, 32'h1234_5678);
        bus_read(32'hA0, d);  check("R2 unlisted offset reads 0", d, 32'h0);
        bus_read(32'h18, d);  check("R12 control reads 0", d, 32'h0);
        bus_read(32'h9C, d);  check("R12 swset reads 0", d, 32'h0);
        bus_write(32'h04, 32'h0);
    endtask

    task automatic t_cfg();
        logic [31:0] d;
        bus_write(32'h38, 32'hFFFF_FFAB);
        bus_read(32'h38, d);  check("R3 line7 cfg readback", d, 32'h0000_002B);
        bus_read(32'h34, d);  check("R3 neighbour line6 untouched", d, 32'h0);
        bus_write(32'h38, 32'h0);
    endtask

    task automatic t_edge();
        logic [31:0] d;
        line_n[3] = 1'b0;
        tick();
        check("R4 irq after falling edge", {31'b0, irq_req_o}, 32'h1);
        bus_read(32'h00, d);  check("R4 pending after edge", d, 32'h0000_0008);
        bus_write(32'h00, 32'h0);
        tick();
        bus_read(32'h00, d);  check("R4 held low does not relatch", d, 32'h0);
        line_n[3] = 1'b1;
        tick();
    endtask

    task automatic t_level();
        logic [31:0] d;
        bus_write(32'h2C, 32'h2);
        line_n[4] = 1'b0;
        tick();
        bus_read(32'h00, d);  check("R5 level pending", d, 32'h0000_0010);
        bus_write(32'h00, 32'h0);
        bus_read(32'h00, d);  check("R6 asserted level survives clear", d, 32'h0000_0010);
        line_n[4] = 1'b1;
        bus_write(32'h00, 32'h0);
        bus_read(32'h00, d);  check("R6 released level clears", d, 32'h0);
        bus_write(32'h9C, 32'h1800_0000);
        bus_read(32'h00, d);  check("R13 swset raises pending", d, 32'h1800_0000);
        bus_write(32'h00, 32'hF7FF_FFFF);
        bus_read(32'h00, d);  check("R6 AND clears one bit", d, 32'h1000_0000);
        bus_write(32'h00, 32'h0);
    endtask

    task automatic t_mask();
        logic [31:0] d;
        bus_write(32'h9C, 32'h0000_0200);
        check("R7 unmasked line requests", {31'b0, irq_req_o}, 32'h1);
        bus_write(32'h04, 32'h0000_0200);
        check("R7 masked line silent", {31'b0, irq_req_o}, 32'h0);
        bus_read(32'h00, d);  check("R7 mask keeps pending", d, 32'h0000_0200);
        bus_write(32'h04, 32'h0);
        check("R7 unmask restores request", {31'b0, irq_req_o}, 32'h1);
        bus_write(32'h00, 32'h0);
    endtask

    task automatic t_arb();
        logic [31:0] d;
        bus_write(32'h44, 32'h14);   // line 10, prio 5
        bus_write(32'h6C, 32'h08);   // line 20, prio 2
        bus_write(32'h70, 32'h08);   // line 21, prio 2
        bus_write(32'h9C, 32'h0030_0400);
        bus_read(32'h10, d);  check("R8 tie goes to lower line", d, 32'd20);
        check("R10 irq held after ack", {31'b0, irq_req_o}, 32'h0);
        bus_read(32'h00, d);  check("R9 ack clears winner", d, 32'h0020_0400);
        bus_write(32'h18, 32'h2);
        check("R10 fiq rearm leaves irq held", {31'b0, irq_req_o}, 32'h0);
        bus_write(32'h18, 32'h1);
        check("R10 irq rearmed", {31'b0, irq_req_o}, 32'h1);
        bus_read(32'h10, d);  check("R8 next winner", d, 32'd21);
        bus_write(32'h18, 32'h1);
        bus_read(32'h10, d);  check("R8 lowest value wins last", d, 32'd10);
        bus_write(32'h18, 32'h1);
        check("R9 no request when empty", {31'b0, irq_req_o}, 32'h0);
        bus_read(32'h10, d);  check("R9 empty code reads 0", d, 32'h0);
        bus_write(32'h18, 32'h1);
    endtask

    task automatic t_fiq();
        logic [31:0] d;
        bus_write(32'h24, 32'h0D);   // line 2, prio 3, edge, FIQ
        bus_write(32'h9C, 32'h0000_0404);
        check("R8 fiq requests", {31'b0, fiq_req_o}, 32'h1);
        check("R8 irq requests", {31'b0, irq_req_o}, 32'h1);
        bus_read(32'h14, d);  check("R9 fiq code", d, 32'd2);
        check("R10 fiq held after ack", {31'b0, fiq_req_o}, 32'h0);
        check("R10 irq unaffected", {31'b0, irq_req_o}, 32'h1);
        bus_write(32'h10, 32'h0);
        bus_write(32'h14, 32'hFFFF_FFFF);
        bus_read(32'h00, d);  check("R11 code writes ignored", d, 32'h0000_0400);
        check("R11 irq still live", {31'b0, irq_req_o}, 32'h1);
        bus_read(32'h10, d);  check("R9 irq code", d, 32'd10);
        bus_write(32'h18, 32'h3);
        bus_read(32'h00, d);  check("R9 all acknowledged", d, 32'h0);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_map();
        t_cfg();
        t_edge();
        t_level();
        t_mask();
        t_arb();
        t_fiq();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

endmodule